// File: doc/BRIEF.md
# Linked-Descriptor Display Fetch Engine

This block feeds a display timing pipeline with words from memory. Software places descriptors in memory and gives the block the address of the first one. Each descriptor is four 32-bit words. It names the next descriptor, a source address, an identifier for the frame, and a command word. The command word gives the length of the transfer and says whether the data is pixels or a palette.

The engine reads the descriptor with a four-word burst. It then reads the source region in bursts of at most sixteen words. Pixel words go into an on-chip FIFO. The timing side pops that FIFO one word at a time. Palette words go out on a write port as pairs of 16-bit entries. When a transfer ends, the engine follows the next pointer.

Two linkings cover the common cases:
- A descriptor that points at itself refreshes the same frame without end.
- Two descriptors that point at each other alternate a palette load with a frame load, with no software involved.

If the timing side reads an empty FIFO, it gets the last word again and a sticky flag records the underrun.

Top module: `frame_dma_fetcher`

## Requirements
- R1: When `enable` is high in idle, the first memory request reads 4 words at byte address `first_desc`. The words arrive in this order: word 0 is the next-descriptor byte address, word 1 is the source byte address, word 2 is the frame identifier, and word 3 is the command.
- R2: Command bits [23:0] give the transfer length in 32-bit words. The data is requested as consecutive bursts of 16 words from the source address, with byte addresses rising by 64 per burst. Only the final burst may be shorter, and it carries the remainder. A request holds its address and length steady until `mem_gnt`.
- R3: When a transfer completes, the next request reads the 4-word descriptor at the next-descriptor address. A descriptor that links to itself repeats its transfer indefinitely.
- R4: When command bit 28 is 1, the words go to the palette port and never reach the pixel FIFO. Each word produces one `pal_we` cycle. Bits [15:0] are the entry at even index `pal_idx` and bits [31:16] are the entry at `pal_idx+1`. `pal_idx` starts at 0 for each palette transfer and advances by 2 per word.
- R5: Pixel words leave in the order they were fetched. A `pix_rd` pulse in one cycle presents the popped word on `pix_data` in the next cycle.
- R6: A `pix_rd` while the FIFO is empty leaves `pix_data` unchanged, repeating the last word. It also sets `underrun`, which stays set until reset.
- R7: `frame_id` takes word 2 of each descriptor as that descriptor is loaded.
- R8: `frame_done` pulses for one cycle at the end of each transfer whose bit 28 is 0. It does not pulse for palette transfers.
- R9: A pixel burst is requested only when the FIFO has free space for all of its words, so the FIFO never overflows.
- R10: After reset, the following are all zero: `mem_req`, `pal_we`, `frame_done`, `underrun`, `frame_id` and `pix_data`.
- R11: When `enable` is low at the end of a transfer, the engine returns to idle and fetches no further descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Start from idle and continue chaining while high |
| first_desc | input | 32 | Byte address of the first descriptor |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | 32 | Burst start byte address |
| mem_len | output | 5 | Burst length in words |
| mem_gnt | input | 1 | Request accepted in this cycle |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |
| pix_rd | input | 1 | Pop one pixel word |
| pix_data | output | 32 | Popped pixel word |
| underrun | output | 1 | Sticky empty-read flag |
| pal_we | output | 1 | Palette pair write strobe |
| pal_idx | output | 8 | Index of the low entry of the pair |
| pal_data | output | 32 | Two 16-bit palette entries |
| frame_id | output | 32 | Identifier of the loaded descriptor |
| frame_done | output | 1 | End of a pixel transfer |

## Verification
The hardest state to reach from the ports is a clean stop on a descriptor boundary, with the FIFO holding a complete frame. Reaching it depends on the `enable` timing in a mutually linked palette/frame chain. The bench lowers `enable` once the second descriptor request has been granted. The engine then finishes that frame and goes idle. After that the FIFO is drained word by word and read once more while empty, which makes the underrun repeat observable. A second run uses a self-linked 40-word frame with a slow reader, so that the room check stalls bursts while the word order is still compared across several frame wraps.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DREQ, ST_DDATA, ST_XREQ, ST_XGNT, ST_XDATA
  } fetch_state_t;
  localparam int DESC_WORDS = 4;
endpackage

// File: rtl/fdf_fifo.sv
module fdf_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  parameter bit HOLD  = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [DW-1:0]              wdata,
  input  logic                       pop,
  output logic [DW-1:0]              rdata,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       underrun
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          do_pop;
  logic [DW-1:0] empty_val;

  assign do_pop = pop && (count != '0);

  generate
    if (HOLD) begin : g_hold
      assign empty_val = rdata;
    end else begin : g_zero
      assign empty_val = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) store[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      underrun <= 1'b0;
      rdata    <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (do_pop) begin
        rptr  <= rptr + 1'b1;
        rdata <= store[rptr];
      end else if (pop) begin
        rdata    <= empty_val;
        underrun <= 1'b1;
      end
      count <= count + (PW+1)'(push) - (PW+1)'(do_pop);
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    push |-> (int'(count) < DEPTH));
  assert_underrun_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);
  assert_hold_on_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (HOLD && pop && count == '0) |=> ($stable(rdata) && underrun));
endmodule

// File: rtl/fdf_engine.sv
module fdf_engine
  import fdf_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int LEN_W   = 24,
  parameter int PAL_BIT = 28,
  parameter int BURST   = 16,
  parameter int DEPTH   = 32,
  parameter int PAL_AW  = 8,
  localparam int BL_W   = $clog2(BURST) + 1,
  localparam int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [AW-1:0]     first_desc,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  output logic [BL_W-1:0]   mem_len,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DW-1:0]     mem_rdata,
  input  logic [CNT_W-1:0]  fifo_count,
  output logic              push,
  output logic              pal_we,
  output logic [PAL_AW-1:0] pal_idx,
  output logic [DW-1:0]     pal_data,
  output logic [DW-1:0]     frame_id,
  output logic              frame_done
);
  fetch_state_t      state;
  logic [AW-1:0]     nxt_ptr, src;
  logic [LEN_W-1:0]  remaining;
  logic              is_pal;
  logic [BL_W-1:0]   beat, blen, blen_next;
  logic [PAL_AW-1:0] pal_cnt;
  logic              room;

  assign blen_next = (remaining >= LEN_W'(BURST)) ? BL_W'(BURST) : remaining[BL_W-1:0];
  assign room      = (int'(fifo_count) + int'(blen_next)) <= DEPTH;
  assign push      = (state == ST_XDATA) && mem_rvalid && !is_pal;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      mem_len    <= '0;
      nxt_ptr    <= '0;
      src        <= '0;
      remaining  <= '0;
      is_pal     <= 1'b0;
      beat       <= '0;
      blen       <= '0;
      pal_cnt    <= '0;
      pal_we     <= 1'b0;
      pal_idx    <= '0;
      pal_data   <= '0;
      frame_id   <= '0;
      frame_done <= 1'b0;
    end else begin
      pal_we     <= 1'b0;
      frame_done <= 1'b0;
      case (state)
        ST_IDLE: if (enable) begin
          mem_addr <= first_desc;
          mem_len  <= BL_W'(DESC_WORDS);
          mem_req  <= 1'b1;
          state    <= ST_DREQ;
        end
        ST_DREQ: if (mem_gnt) begin
          mem_req <= 1'b0;
          beat    <= '0;
          state   <= ST_DDATA;
        end
        ST_DDATA: if (mem_rvalid) begin
          beat <= beat + 1'b1;
          case (beat[1:0])
            2'd0: nxt_ptr  <= mem_rdata;
            2'd1: src      <= mem_rdata;
            2'd2: frame_id <= mem_rdata;
            default: begin
              remaining <= mem_rdata[LEN_W-1:0];
              is_pal    <= mem_rdata[PAL_BIT];
              pal_cnt   <= '0;
              state     <= ST_XREQ;
            end
          endcase
        end
        ST_XREQ: begin
          if (remaining == '0) begin
            frame_done <= !is_pal;
            if (enable) begin
              mem_addr <= nxt_ptr;
              mem_len  <= BL_W'(DESC_WORDS);
              mem_req  <= 1'b1;
              state    <= ST_DREQ;
            end else begin
              state <= ST_IDLE;
            end
          end else if (is_pal || room) begin
            blen     <= blen_next;
            mem_addr <= src;
            mem_len  <= blen_next;
            mem_req  <= 1'b1;
            state    <= ST_XGNT;
          end
        end
        ST_XGNT: if (mem_gnt) begin
          mem_req <= 1'b0;
          beat    <= '0;
          state   <= ST_XDATA;
        end
        ST_XDATA: if (mem_rvalid) begin
          beat <= beat + 1'b1;
          if (is_pal) begin
            pal_we   <= 1'b1;
            pal_idx  <= pal_cnt;
            pal_data <= mem_rdata;
            pal_cnt  <= pal_cnt + PAL_AW'(2);
          end
          if (beat == blen - 1'b1) begin
            src       <= src + (AW'(blen) << 2);
            remaining <= remaining - LEN_W'(blen);
            state     <= ST_XREQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_held_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_len)));
  assert_burst_max_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_len != '0 && int'(mem_len) <= BURST));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  assert_pal_no_push_R4: assert property (@(posedge clk) disable iff (rst)
    pal_we |-> !$past(push));
endmodule

// File: rtl/frame_dma_fetcher.sv
module frame_dma_fetcher #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int LEN_W    = 24,
  parameter int PAL_BIT  = 28,
  parameter int BURST    = 16,
  parameter int DEPTH    = 32,
  parameter int PAL_AW   = 8,
  parameter bit HOLD_UNDERRUN = 1'b1,
  localparam int BL_W    = $clog2(BURST) + 1,
  localparam int CNT_W   = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [AW-1:0]     first_desc,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  output logic [BL_W-1:0]   mem_len,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              pix_rd,
  output logic [DW-1:0]     pix_data,
  output logic              underrun,
  output logic              pal_we,
  output logic [PAL_AW-1:0] pal_idx,
  output logic [DW-1:0]     pal_data,
  output logic [DW-1:0]     frame_id,
  output logic              frame_done
);
  logic             push;
  logic [CNT_W-1:0] fifo_count;

  fdf_engine #(
    .AW(AW), .DW(DW), .LEN_W(LEN_W), .PAL_BIT(PAL_BIT),
    .BURST(BURST), .DEPTH(DEPTH), .PAL_AW(PAL_AW)
  ) u_engine (
    .clk(clk), .rst(rst), .enable(enable), .first_desc(first_desc),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .fifo_count(fifo_count), .push(push),
    .pal_we(pal_we), .pal_idx(pal_idx), .pal_data(pal_data),
    .frame_id(frame_id), .frame_done(frame_done)
  );

  fdf_fifo #(.DW(DW), .DEPTH(DEPTH), .HOLD(HOLD_UNDERRUN)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .wdata(mem_rdata),
    .pop(pix_rd), .rdata(pix_data), .count(fifo_count), .underrun(underrun)
  );
endmodule

// File: tb/frame_dma_fetcher_test.sv
`timescale 1ns/1ps
module frame_dma_fetcher_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [31:0] first_desc = 32'h100;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [4:0]  mem_len;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        pix_rd = 1'b0;
  logic [31:0] pix_data;
  logic        underrun;
  logic        pal_we;
  logic [7:0]  pal_idx;
  logic [31:0] pal_data;
  logic [31:0] frame_id;
  logic        frame_done;

  always #2.5 clk = ~clk;

  frame_dma_fetcher uut (
    .clk(clk), .rst(rst), .enable(enable), .first_desc(first_desc),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .pix_rd(pix_rd), .pix_data(pix_data), .underrun(underrun),
    .pal_we(pal_we), .pal_idx(pal_idx), .pal_data(pal_data),
    .frame_id(frame_id), .frame_done(frame_done)
  );

  function automatic logic [31:0] fw(input int w);
    return {16'(w + 32'h3000), 16'(w ^ 32'hF0)};
  endfunction

  logic [31:0] mem [512];
  int n_chk = 0, n_bad = 0, m_chk = 0, m_bad = 0;
  int ph = 0, req_total = 0, req_base = 0, pal_total = 0, done_total = 0;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic exp_req(input int p, input int i, output logic [31:0] a, output int l, output string r);
    a = 32'hDEAD; l = 0; r = "R11";
    if (p == 2) begin
      if (i == 0)             begin a = 32'h100; l = 4; r = "R1"; end
      else if (i <= 8)        begin a = 32'h200 + 32'((i-1)*64); l = 16; r = "R2"; end
      else if (i == 9)        begin a = 32'h110; l = 4; r = "R3"; end
      else if (i == 10)       begin a = 32'h400; l = 16; r = "R2"; end
      else if (i == 11)       begin a = 32'h440; l = 8; r = "R2"; end
    end else if (p == 3) begin
      case (i % 4)
        0: begin a = 32'h120; l = 4;  r = (i == 0) ? "R1" : "R3"; end
        1: begin a = 32'h600; l = 16; r = "R2"; end
        2: begin a = 32'h640; l = 16; r = "R9"; end
        default: begin a = 32'h680; l = 8; r = "R2"; end
      endcase
    end
  endtask

  // memory model and monitors
  int cyc = 0, b_left = 0;
  logic [31:0] b_addr = '0, lat_addr = '0;
  int lat_len = 0;
  bit acc_pend = 0;
  always @(negedge clk) begin
    logic [31:0] ea;
    int el, k;
    string er;
    cyc++;
    if (acc_pend) begin
      exp_req(ph, req_total - req_base, ea, el, er);
      m_chk++;
      if (lat_addr != ea || lat_len != el) begin
        m_bad++;
        $display("FAIL %s: request %0d actual %h/%0d expected %h/%0d",
                 er, req_total - req_base, lat_addr, lat_len, ea, el);
      end
      req_total++;
      b_addr = lat_addr;
      b_left = lat_len;
    end
    acc_pend = 0;
    mem_rvalid = 1'b0;
    if (b_left > 0 && (cyc % 7) != 3) begin
      mem_rvalid = 1'b1;
      mem_rdata  = mem[b_addr[10:2]];
      b_addr += 4;
      b_left--;
    end
    mem_gnt = (b_left == 0) && ((cyc % 4) != 1);
    if (mem_req && mem_gnt) begin
      acc_pend = 1;
      lat_addr = mem_addr;
      lat_len  = int'(mem_len);
    end
    if (pal_we) begin
      k = pal_total % 128;
      m_chk++;
      if (pal_idx != 8'(2*k) || pal_data != fw(128 + k)) begin
        m_bad++;
        $display("FAIL R4: palette write %0d actual %h/%h expected %h/%h",
                 k, pal_idx, pal_data, 8'(2*k), fw(128 + k));
      end
      if (k == 0) begin
        m_chk++;
        if (frame_id != 32'hAA) begin
          m_bad++;
          $display("FAIL R7: frame_id during palette actual %h expected %h", frame_id, 32'hAA);
        end
      end
      pal_total++;
    end
    if (frame_done) done_total++;
  end

  bit finished = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + m_chk + 1, n_bad + m_bad);
      $finish;
    end
  end

  initial begin
    int db, pb;
    for (int i = 0; i < 512; i++) mem[i] = fw(i);
    mem[64] = 32'h110; mem[65] = 32'h200; mem[66] = 32'hAA; mem[67] = (32'd1 << 28) | 32'd128;
    mem[68] = 32'h100; mem[69] = 32'h400; mem[70] = 32'h55; mem[71] = 32'd24;
    mem[72] = 32'h120; mem[73] = 32'h600; mem[74] = 32'h77; mem[75] = 32'd40;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_req == 0,    "R10", 32'(mem_req), 0);
    chk(pal_we == 0,     "R10", 32'(pal_we), 0);
    chk(frame_done == 0, "R10", 32'(frame_done), 0);
    chk(underrun == 0,   "R10", 32'(underrun), 0);
    chk(frame_id == 0,   "R10", frame_id, 0);
    chk(pix_data == 0,   "R10", pix_data, 0);

    // mutual palette/frame chain, stop after the frame
    ph = 2; req_base = req_total;
    enable = 1'b1;
    while (req_total - req_base < 10) @(negedge clk);
    enable = 1'b0;
    while (done_total < 1) @(negedge clk);
    repeat (100) @(negedge clk);
    chk(req_total - req_base == 12, "R11", 32'(req_total - req_base), 12);
    chk(pal_total == 128, "R4", 32'(pal_total), 128);
    chk(frame_id == 32'h55, "R7", frame_id, 32'h55);
    chk(done_total == 1, "R8", 32'(done_total), 1);
    chk(underrun == 0, "R6", 32'(underrun), 0);
    pix_rd = 1'b1;
    for (int n = 0; n < 24; n++) begin
      @(negedge clk);
      chk(pix_data == fw(256 + n), "R5", pix_data, fw(256 + n));
    end
    chk(underrun == 0, "R6", 32'(underrun), 0);
    @(negedge clk);
    pix_rd = 1'b0;
    chk(pix_data == fw(279), "R6", pix_data, fw(279));
    chk(underrun == 1, "R6", 32'(underrun), 1);
    repeat (5) @(negedge clk);
    chk(underrun == 1, "R6", 32'(underrun), 1);
    chk(pix_data == fw(279), "R6", pix_data, fw(279));

    // self-linked frame with a slow reader
    ph = 3; req_base = req_total; db = done_total; pb = pal_total;
    first_desc = 32'h120;
    enable = 1'b1;
    repeat (200) @(negedge clk);
    for (int n = 0; n < 100; n++) begin
      pix_rd = 1'b1;
      @(negedge clk);
      pix_rd = 1'b0;
      chk(pix_data == fw(384 + n % 40), "R5", pix_data, fw(384 + n % 40));
      @(negedge clk);
      @(negedge clk);
    end
    enable = 1'b0;
    repeat (300) @(negedge clk);
    chk(done_total - db >= 2, "R3", 32'(done_total - db), 2);
    chk(pal_total == pb, "R4", 32'(pal_total - pb), 0);
    chk(frame_id == 32'h77, "R7", frame_id, 32'h77);
    chk(underrun == 1, "R6", 32'(underrun), 1);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(underrun == 0, "R10", 32'(underrun), 0);
    chk(frame_id == 0, "R10", frame_id, 0);
    chk(pix_data == 0, "R10", pix_data, 0);
    chk(mem_req == 0,  "R10", 32'(mem_req), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + m_chk, n_bad + m_bad);
    $finish;
  end
endmodule